// File: doc/BRIEF.md
# Prioritized Multi-Source Reset Controller

This block decides which device reset to run when several reset sources compete. It watches a power-on reset pin, a warm reset pin, a single-cycle system reset request from a debug or link path, and one watchdog request per core. When more than one device-level request is pending, it picks the strongest one. It then steps the chip through a fixed reset sequence: hold the internal logic in reset, release it, pulse a start signal for initialization or boot, and wait for a completion handshake. Throughout, it drives an active-low device reset status output.

The three device-level classes differ in scope. Power-on and warm resets are hard: they float the I/O pads and clear the retention domains. A system reset is soft: it resets logic but leaves the retention domains and the clock and power state alone. Only power-on samples the configuration pins into the boot-mode register. A warm reset counts only after its pin has stayed low long enough. Watchdog requests are handled apart from the device sequence. Each one resets only its own core for a fixed time, and the device status does not change.

Top module: `rstc_top`

## Requirements
- R1: When a qualified warm request and a system request reach the sequencer on the same clock edge, the warm request is taken (`cause` = 2) and the system request is discarded. Power-on outranks both.
- R2: The warm pin triggers a reset only on the 24th consecutive clock edge at which it is sampled low. A low pulse of 23 samples leaves every output unchanged.
- R3: `pad_hiz` is 1 in the hold phase of a power-on or warm sequence and 0 in the hold phase of a system sequence. It is 0 outside the hold phase.
- R4: `status_n` is 0 from the first hold cycle through the initialization wait. It returns to 1 only on the clock edge after `init_done` is sampled 1.
- R5: `boot_mode` takes the value of `cfg_pins` on the first clock edge after `por_n` goes high, and is 0 before that. Warm and system resets leave it unchanged.
- R6: A system sequence drives `logic_rst_n` low while `retain_rst_n` stays 1. Power-on and warm sequences drive both low in the hold phase.
- R7: `cause` reports the source of the latest device sequence and keeps that value until a new sequence starts. The codes are 3 for power-on, 2 for warm and 1 for system.
- R8: A higher-priority request that arrives during a sequence restarts it at the hold phase with the new cause. A request of equal or lower priority arriving during a sequence is dropped and does not rerun the sequence later.
- R9: A pulse on `wdog_req[i]` drives `core_rst_n[i]` low for exactly 8 cycles, retriggering on a new pulse. The other cores and `status_n` are unaffected.
- R10: For system and power-on sequences the hold phase lasts 4 cycles. For warm sequences it lasts at least 4 cycles and continues while the pin stays low. It is followed by one cycle with `init_start` = 1 and `logic_rst_n` = 1, then the initialization wait.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| por_n | input | 1 | Power-on reset pin, active low, asynchronous assert |
| warm_n | input | 1 | Warm reset pin, active low, synchronous to clk |
| sys_req | input | 1 | System (soft) reset request, single-cycle pulse |
| wdog_req | input | 3 | Per-core watchdog reset request pulses |
| init_done | input | 1 | Initialization or boot complete handshake |
| cfg_pins | input | 4 | Boot-mode configuration pins |
| status_n | output | 1 | Device reset status, low while a device reset is active |
| logic_rst_n | output | 1 | Internal logic reset, active low |
| retain_rst_n | output | 1 | Retention domain reset, active low, hard resets only |
| pad_hiz | output | 1 | Tri-state enable for the I/O pads |
| init_start | output | 1 | One-cycle pulse that starts initialization or boot |
| boot_mode | output | 4 | Latched boot mode |
| cause | output | 2 | Source of the latest device sequence |
| core_rst_n | output | 3 | Per-core local reset, active low |

## Verification
Some properties are checked on every cycle. `status_n` may rise only right after `init_done` was high. The pads float only while logic reset is applied. The cause never drops during an active sequence. The boot mode stays frozen after its single sample. `init_start` never lasts two cycles. Each watchdog pulse is followed by a held core reset. The bench scenarios show what a property cannot express: the exact 23-versus-24 cycle qualification boundary, the hold length, the drop of a system request that arrives during a warm hold, preemption of a system sequence mid-initialization, and the full 8-cycle core reset window with retrigger.

// File: rtl/rstc_pkg.sv
package rstc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_QUALIFY,
        ST_HOLD,
        ST_RELEASE,
        ST_INIT,
        ST_DONE
    } seq_state_e;

    // numeric value equals priority
    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_SYS  = 2'd1,
        SRC_WARM = 2'd2,
        SRC_POR  = 2'd3
    } src_e;

endpackage

// File: rtl/rstc_warm_filter.sv
module rstc_warm_filter #(
    parameter int MIN_LOW = 24
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic fire
);
    localparam int CW = $clog2(MIN_LOW + 1);
    localparam logic [CW-1:0] CNT_MAX  = CW'(MIN_LOW);
    localparam logic [CW-1:0] CNT_LAST = CW'(MIN_LOW - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (pin_n) begin
            cnt_d = '0;
        end else if (cnt_q != CNT_MAX) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign fire = !pin_n && (cnt_q == CNT_LAST);

    // R2: one request per qualified low period
    a_r2_single_fire: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> !fire);

endmodule

// File: rtl/rstc_sequencer.sv
module rstc_sequencer
    import rstc_pkg::*;
#(
    parameter int HOLD_CYC = 4,
    parameter int BOOT_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              warm_n,
    input  logic              warm_fire,
    input  logic              sys_req,
    input  logic              init_done,
    input  logic [BOOT_W-1:0] cfg_pins,
    output logic              status_n,
    output logic              logic_rst_n,
    output logic              retain_rst_n,
    output logic              pad_hiz,
    output logic              init_start,
    output logic [BOOT_W-1:0] boot_mode,
    output logic [1:0]        cause
);
    localparam int HW = $clog2(HOLD_CYC + 1);
    localparam logic [HW-1:0] HOLD_LAST = HW'(HOLD_CYC - 1);

    typedef struct packed {
        seq_state_e        state;
        src_e              src;
        logic [HW-1:0]     hcnt;
        logic [BOOT_W-1:0] boot;
        logic              first;
    } seq_regs_t;

    seq_regs_t regs_d, regs_q;
    src_e      req_src;
    logic      in_seq;
    logic      hold_more;

    assign in_seq = (regs_q.state == ST_HOLD) || (regs_q.state == ST_RELEASE) ||
                    (regs_q.state == ST_INIT);

    always_comb begin
        if (warm_fire)    req_src = SRC_WARM;
        else if (sys_req) req_src = SRC_SYS;
        else              req_src = SRC_NONE;
    end

    assign hold_more = (regs_q.hcnt < HOLD_LAST) ||
                       ((regs_q.src == SRC_WARM) && !warm_n);

    always_comb begin
        regs_d = regs_q;
        if (regs_q.first) begin
            regs_d.boot  = cfg_pins;
            regs_d.first = 1'b0;
        end
        case (regs_q.state)
            ST_IDLE, ST_QUALIFY, ST_DONE: begin
                if (req_src != SRC_NONE) begin
                    regs_d.state = ST_HOLD;
                    regs_d.src   = req_src;
                    regs_d.hcnt  = '0;
                end else if (!warm_n) begin
                    regs_d.state = ST_QUALIFY;
                end else begin
                    regs_d.state = ST_IDLE;
                end
            end
            ST_HOLD: begin
                if (hold_more) begin
                    if (regs_q.hcnt < HOLD_LAST) regs_d.hcnt = regs_q.hcnt + 1'b1;
                end else begin
                    regs_d.state = ST_RELEASE;
                end
            end
            ST_RELEASE: regs_d.state = ST_INIT;
            ST_INIT: if (init_done) regs_d.state = ST_DONE;
            default: regs_d.state = ST_IDLE;
        endcase
        // preemption by a stronger source; weaker or equal ones are dropped
        if (in_seq && (req_src > regs_q.src)) begin
            regs_d.state = ST_HOLD;
            regs_d.src   = req_src;
            regs_d.hcnt  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q.state <= ST_HOLD;
            regs_q.src   <= SRC_POR;
            regs_q.hcnt  <= '0;
            regs_q.boot  <= '0;
            regs_q.first <= 1'b1;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign status_n     = !in_seq;
    assign logic_rst_n  = (regs_q.state != ST_HOLD);
    assign retain_rst_n = !((regs_q.state == ST_HOLD) && (regs_q.src != SRC_SYS));
    assign pad_hiz      = (regs_q.state == ST_HOLD) && (regs_q.src != SRC_SYS);
    assign init_start   = (regs_q.state == ST_RELEASE);
    assign boot_mode    = regs_q.boot;
    assign cause        = regs_q.src;

    // R4: status may only rise after completion was seen
    a_r4_status_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_n) |-> $past(init_done));

    // R3: pads float only while logic reset is applied
    a_r3_hiz_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
        pad_hiz |-> !logic_rst_n);

    // R8: cause never weakens inside a running sequence
    a_r8_no_downgrade: assert property (@(posedge clk) disable iff (!rst_n)
        (in_seq && $past(in_seq)) |-> (regs_q.src >= $past(regs_q.src)));

    // R5: boot mode frozen after its single sample
    a_r5_boot_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (!regs_q.first && !$past(regs_q.first)) |-> $stable(boot_mode));

    // R10: start pulse lasts one cycle
    a_r10_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        init_start |=> !init_start);

endmodule

// File: rtl/rstc_core_hold.sv
module rstc_core_hold #(
    parameter int N_CORES  = 3,
    parameter int HOLD_CYC = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               dev_rst_n,
    input  logic [N_CORES-1:0] wdog_req,
    output logic [N_CORES-1:0] core_rst_n
);
    localparam int CW = $clog2(HOLD_CYC + 1);
    localparam logic [CW-1:0] CNT_LOAD = CW'(HOLD_CYC);

    for (genvar i = 0; i < N_CORES; i++) begin : g_core
        logic [CW-1:0] cnt_d, cnt_q;

        always_comb begin
            cnt_d = cnt_q;
            if (wdog_req[i])        cnt_d = CNT_LOAD;
            else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) cnt_q <= '0;
            else        cnt_q <= cnt_d;
        end

        assign core_rst_n[i] = (cnt_q == '0) && dev_rst_n;

        // R9: a watchdog pulse puts its core into reset
        a_r9_core_hit: assert property (@(posedge clk) disable iff (!rst_n)
            wdog_req[i] |=> !core_rst_n[i]);
    end

endmodule

// File: rtl/rstc_top.sv
module rstc_top #(
    parameter int N_CORES   = 3,
    parameter int WARM_MIN  = 24,
    parameter int HOLD_CYC  = 4,
    parameter int CORE_HOLD = 8,
    parameter int BOOT_W    = 4
) (
    input  logic               clk,
    input  logic               por_n,
    input  logic               warm_n,
    input  logic               sys_req,
    input  logic [N_CORES-1:0] wdog_req,
    input  logic               init_done,
    input  logic [BOOT_W-1:0]  cfg_pins,
    output logic               status_n,
    output logic               logic_rst_n,
    output logic               retain_rst_n,
    output logic               pad_hiz,
    output logic               init_start,
    output logic [BOOT_W-1:0]  boot_mode,
    output logic [1:0]         cause,
    output logic [N_CORES-1:0] core_rst_n
);
    logic warm_fire;

    rstc_warm_filter #(.MIN_LOW(WARM_MIN)) u_filter (
        .clk   (clk),
        .rst_n (por_n),
        .pin_n (warm_n),
        .fire  (warm_fire)
    );

    rstc_sequencer #(.HOLD_CYC(HOLD_CYC), .BOOT_W(BOOT_W)) u_seq (
        .clk          (clk),
        .rst_n        (por_n),
        .warm_n       (warm_n),
        .warm_fire    (warm_fire),
        .sys_req      (sys_req),
        .init_done    (init_done),
        .cfg_pins     (cfg_pins),
        .status_n     (status_n),
        .logic_rst_n  (logic_rst_n),
        .retain_rst_n (retain_rst_n),
        .pad_hiz      (pad_hiz),
        .init_start   (init_start),
        .boot_mode    (boot_mode),
        .cause        (cause)
    );

    rstc_core_hold #(.N_CORES(N_CORES), .HOLD_CYC(CORE_HOLD)) u_cores (
        .clk        (clk),
        .rst_n      (por_n),
        .dev_rst_n  (logic_rst_n),
        .wdog_req   (wdog_req),
        .core_rst_n (core_rst_n)
    );

endmodule

// File: tb/sim_rstc_top.sv
module sim_rstc_top;
    localparam int CLK_PERIOD = 10;
    localparam logic [1:0] C_POR = 2'd3, C_WARM = 2'd2, C_SYS = 2'd1;

    logic       clk = 1'b0;
    logic       por_n, warm_n, sys_req, init_done;
    logic [2:0] wdog_req;
    logic [3:0] cfg_pins;
    logic       status_n, logic_rst_n, retain_rst_n, pad_hiz, init_start;
    logic [3:0] boot_mode;
    logic [1:0] cause;
    logic [2:0] core_rst_n;

    rstc_top u0 (
        .clk(clk), .por_n(por_n), .warm_n(warm_n), .sys_req(sys_req),
        .wdog_req(wdog_req), .init_done(init_done), .cfg_pins(cfg_pins),
        .status_n(status_n), .logic_rst_n(logic_rst_n), .retain_rst_n(retain_rst_n),
        .pad_hiz(pad_hiz), .init_start(init_start), .boot_mode(boot_mode),
        .cause(cause), .core_rst_n(core_rst_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        int          at;
        string       tag;
        logic [13:0] exp;
    } item_t;

    item_t       sb[$];
    int          cyc = 0;
    int          n_chk = 0;
    int          n_bad = 0;
    logic [3:0]  bm = 4'h0;
    logic [13:0] obs;

    assign obs = {status_n, logic_rst_n, retain_rst_n, pad_hiz, init_start,
                  boot_mode, cause, core_rst_n};

    always @(posedge clk) cyc <= cyc + 1;

    // monitor: pops due items and compares
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].at <= cyc) begin
            item_t it;
            it = sb.pop_front();
            n_chk++;
            if (it.at != cyc || obs !== it.exp) begin
                n_bad++;
                $display("FAIL %s: got %b expected %b (cycle %0d)", it.tag, obs, it.exp, cyc);
            end
        end
    end

    function automatic logic [13:0] vec(bit st, bit lg, bit rt, bit hz, bit is,
                                        logic [1:0] ca, logic [2:0] co);
        return {st, lg, rt, hz, is, bm, ca, co};
    endfunction
    function automatic logic [13:0] idlev(logic [1:0] ca, logic [2:0] co);
        return vec(1, 1, 1, 0, 0, ca, co);
    endfunction
    function automatic logic [13:0] holdv(logic [1:0] ca);
        return vec(0, 0, ca == C_SYS, ca != C_SYS, 0, ca, 3'b000);
    endfunction
    function automatic logic [13:0] relv(logic [1:0] ca);
        return vec(0, 1, 1, 0, 1, ca, 3'b111);
    endfunction
    function automatic logic [13:0] initv(logic [1:0] ca);
        return vec(0, 1, 1, 0, 0, ca, 3'b111);
    endfunction

    // driver: queue expectation for the next negedge, then advance
    task automatic tick_exp(string tag, logic [13:0] e);
        item_t it;
        it.at = cyc + 1; it.tag = tag; it.exp = e;
        sb.push_back(it);
        @(negedge clk);
    endtask

    task automatic finish_seq(logic [1:0] ca);
        tick_exp("R10 release pulse", relv(ca));
        tick_exp("R4 init wait", initv(ca));
        tick_exp("R4 still waiting", initv(ca));
        init_done = 1'b1;
        tick_exp("R4 status back after done", idlev(ca, 3'b111));
        init_done = 1'b0;
        tick_exp("R7 cause kept", idlev(ca, 3'b111));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        por_n = 1'b0; warm_n = 1'b1; sys_req = 1'b0; init_done = 1'b0;
        wdog_req = 3'b000; cfg_pins = 4'hA;
        @(negedge clk);
        tick_exp("R3 R6 R7 power-on hold", holdv(C_POR));
        por_n = 1'b1;
        bm = 4'hA;
        tick_exp("R5 boot sampled at release", holdv(C_POR));
        cfg_pins = 4'h5;
        repeat (2) tick_exp("R10 power-on hold length", holdv(C_POR));
        finish_seq(C_POR);

        // system reset: soft
        sys_req = 1'b1;
        tick_exp("R6 system hold keeps retention", holdv(C_SYS));
        sys_req = 1'b0;
        repeat (3) tick_exp("R10 system hold length", holdv(C_SYS));
        finish_seq(C_SYS);

        // warm pulse of 23 samples is ignored
        warm_n = 1'b0;
        repeat (23) tick_exp("R2 short warm ignored", idlev(C_SYS, 3'b111));
        warm_n = 1'b1;
        repeat (2) tick_exp("R2 short warm no effect", idlev(C_SYS, 3'b111));

        // warm pulse of 24 samples, system request during hold dropped
        warm_n = 1'b0;
        repeat (23) tick_exp("R2 warm qualifying", idlev(C_SYS, 3'b111));
        tick_exp("R2 R3 warm accepted", holdv(C_WARM));
        sys_req = 1'b1;
        tick_exp("R8 lower request dropped", holdv(C_WARM));
        sys_req = 1'b0;
        repeat (4) tick_exp("R10 warm hold follows pin", holdv(C_WARM));
        warm_n = 1'b1;
        finish_seq(C_WARM);
        tick_exp("R8 dropped request not replayed", idlev(C_WARM, 3'b111));

        // preemption of a system sequence during init
        sys_req = 1'b1;
        tick_exp("R7 system start", holdv(C_SYS));
        sys_req = 1'b0;
        repeat (3) tick_exp("R10 system hold", holdv(C_SYS));
        tick_exp("R10 system release", relv(C_SYS));
        warm_n = 1'b0;
        repeat (23) tick_exp("R4 init with warm counting", initv(C_SYS));
        tick_exp("R8 warm preempts system", holdv(C_WARM));
        warm_n = 1'b1;
        repeat (3) tick_exp("R8 restarted hold", holdv(C_WARM));
        finish_seq(C_WARM);

        // simultaneous warm and system requests
        warm_n = 1'b0;
        repeat (23) tick_exp("R2 qualify", idlev(C_WARM, 3'b111));
        sys_req = 1'b1;
        tick_exp("R1 warm beats system", holdv(C_WARM));
        sys_req = 1'b0;
        warm_n = 1'b1;
        repeat (3) tick_exp("R1 hold", holdv(C_WARM));
        finish_seq(C_WARM);

        // per-core watchdog resets
        wdog_req = 3'b101;
        tick_exp("R9 cores 0 and 2 reset", idlev(C_WARM, 3'b010));
        wdog_req = 3'b000;
        repeat (7) tick_exp("R9 core hold window", idlev(C_WARM, 3'b010));
        tick_exp("R9 cores released after 8", idlev(C_WARM, 3'b111));
        wdog_req = 3'b010;
        tick_exp("R9 core 1 reset", idlev(C_WARM, 3'b101));
        wdog_req = 3'b000;
        repeat (3) tick_exp("R9 core 1 held", idlev(C_WARM, 3'b101));
        wdog_req = 3'b010;
        tick_exp("R9 retrigger", idlev(C_WARM, 3'b101));
        wdog_req = 3'b000;
        repeat (7) tick_exp("R9 retrigger window", idlev(C_WARM, 3'b101));
        tick_exp("R9 core 1 released", idlev(C_WARM, 3'b111));

        repeat (2) @(negedge clk);
        if (sb.size() != 0) begin
            n_bad += sb.size();
            $display("FAIL scoreboard: got %0d pending expected 0", sb.size());
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule